// File: doc/BRIEF.md
# Eight-Digit Decimal Tally with Capture Registers

This block counts pulses in decimal. It is a chain of BCD decades, eight by default, clocked by one system clock. Each falling edge of the pulse input raises the count by one. The count rolls over to all zeros after the largest value. An active-low clear input zeroes the decades and a sticky overflow flag. A set of capture registers shows the count and the flag at the outputs. While the capture strobe is low these registers follow the live count and flag. After the strobe returns high they keep the last value.

The overflow flag is set by a falling edge on a source chosen by a two-bit selector. The source is either the MSB of one of the three most significant decades or an external overflow pin. The live MSBs of those three decades also appear as outputs, so they can be wired back to the overflow pin.

The pulse, clear, capture and external overflow inputs each pass through a two-flop synchronizer. Edges are found by comparing the current sample with the previous one.

Top module: `tally_top`

## Requirements
- R1: Each falling edge of `cnt_in` raises the count by exactly one. The count appears on `digits_q` once captured. Nibble i of `digits_q` holds decade i+1, and nibble 0 is the least significant decade.
- R2: Every decade always holds a value from 0 to 9. One count after the all-nines value, the count reads all zeros.
- R3: While `clr_n` is low, all decades and the overflow flag clear to zero. When a clear and a count edge reach the counter in the same cycle, the clear wins and the count edge is lost.
- R4: The overflow flag sets on the first falling edge of the selected source and stays set until a clear. A rising edge does not set it. The `ovf_sel` encoding is: 0 selects `msb_tap[0]`, 1 selects `msb_tap[1]`, 2 selects `msb_tap[2]`, and 3 selects the `ovf_in` pin.
- R5: While `load_n` is low, `digits_q` follows the counter and `ovf_q` follows the overflow flag.
- R6: While `load_n` is high, `digits_q` and `ovf_q` hold their values. Counting and clearing do not change them.
- R7: `msb_tap[j]` is the live 8-weight bit of decade DIGITS-2+j, counting decades from 1. With the default of eight digits these are decades 6, 7 and 8.
- R8: A pulse on `cnt_in` that stays high and then low for at least two clocks each is counted exactly once, however long it lasts.
- R9: While `rst_n` is low, all state is cleared: the count, the flag, the capture registers and the synchronizers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cnt_in | input | 1 | Count pulse; each falling edge counts once |
| clr_n | input | 1 | Active-low clear of the count and the overflow flag |
| load_n | input | 1 | Active-low capture strobe |
| ovf_in | input | 1 | External overflow source |
| ovf_sel | input | 2 | Selects the overflow source (see R4) |
| digits_q | output | 4*DIGITS | Captured BCD count; nibble 0 is the least significant decade |
| ovf_q | output | 1 | Captured overflow flag |
| msb_tap | output | 3 | Live MSBs of the three top decades |

## Verification
A level change on `cnt_in`, `clr_n` or `ovf_in` takes effect on the third rising edge after it, once it has crossed the two synchronizer flops and the edge compare. The counter, the flag and `msb_tap` therefore show the result three edges after the change. The capture registers take the new value on that same third edge of a low `load_n`. The bench changes inputs on falling edges and holds every level for at least three falling edges before it samples. In the clear-priority case, the clear pulse lasts exactly one clock and is driven on the same falling edge as the count edge, so both reach the counter together. A three-digit configuration is swept through the full rollover, which lets every count value be checked against arithmetic in the bench.

// File: rtl/tally_pkg.sv
package tally_pkg;
  typedef logic [3:0] bcd_t;
  localparam bcd_t BCD_TOP = 4'd9;

  function automatic bcd_t bcd_next(input bcd_t v);
    return (v == BCD_TOP) ? 4'd0 : v + 4'd1;
  endfunction
endpackage

// File: rtl/tally_sync.sv
module tally_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= IDLE;
      q        <= IDLE;
    end else begin
      stage1_q <= d;
      q        <= stage1_q;
    end
  end
endmodule

// File: rtl/tally_chain.sv
module tally_chain
  import tally_pkg::*;
#(
  parameter int DIGITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                clr,
  output logic [4*DIGITS-1:0] count_q
);
  // ripple[k]: decades 1..k all hold nine and a step is due
  logic [DIGITS:0] ripple;
  assign ripple[0] = step;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dec
    bcd_t dec_q, dec_d;

    assign ripple[g+1] = ripple[g] & (dec_q == BCD_TOP);

    always_comb begin
      if (clr)            dec_d = '0;
      else if (ripple[g]) dec_d = bcd_next(dec_q);
      else                dec_d = dec_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dec_q <= '0;
      else        dec_q <= dec_d;
    end

    assign count_q[4*g +: 4] = dec_q;
  end
endmodule

// File: rtl/tally_hold.sv
module tally_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  input  logic         flag_d,
  output logic [W-1:0] q,
  output logic         flag_q
);
  logic [W-1:0] q_nx;
  logic         flag_nx;

  always_comb begin
    q_nx    = cap ? d      : q;
    flag_nx = cap ? flag_d : flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      flag_q <= 1'b0;
    end else begin
      q      <= q_nx;
      flag_q <= flag_nx;
    end
  end
endmodule

// File: rtl/tally_top.sv
module tally_top #(
  parameter int DIGITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_in,
  input  logic                clr_n,
  input  logic                load_n,
  input  logic                ovf_in,
  input  logic [1:0]          ovf_sel,
  output logic [4*DIGITS-1:0] digits_q,
  output logic                ovf_q,
  output logic [2:0]          msb_tap
);
  localparam int WBUS  = 4 * DIGITS;
  localparam int NSYNC = 4;
  localparam int TAP0  = DIGITS - 3;
  // bit order {ovf_in, load_n, clr_n, cnt_in}; idle levels 0,1,1,0
  localparam logic [NSYNC-1:0] SYNC_IDLE = 4'b0110;

  logic [NSYNC-1:0] sync_q;
  logic             cnt_s, clr_s, cap_s, ext_s;
  logic             cnt_prev_q, cnt_prev_d;
  logic             src_prev_q, src_prev_d;
  logic             flag_q, flag_d;
  logic             src_now, src_fall, step;
  logic [WBUS-1:0]  count_flat;

  tally_sync #(.W(NSYNC), .IDLE(SYNC_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ovf_in, load_n, clr_n, cnt_in}),
    .q(sync_q)
  );

  assign cnt_s = sync_q[0];
  assign clr_s = ~sync_q[1];
  assign cap_s = ~sync_q[2];
  assign ext_s = sync_q[3];

  tally_chain #(.DIGITS(DIGITS)) u_chain (
    .clk(clk), .rst_n(rst_n), .step(step), .clr(clr_s), .count_q(count_flat)
  );

  for (genvar j = 0; j < 3; j++) begin : g_tap
    assign msb_tap[j] = count_flat[4*(TAP0+j) + 3];
  end

  always_comb begin
    case (ovf_sel)
      2'd0:    src_now = msb_tap[0];
      2'd1:    src_now = msb_tap[1];
      2'd2:    src_now = msb_tap[2];
      default: src_now = ext_s;
    endcase
    step       = cnt_prev_q & ~cnt_s;
    src_fall   = src_prev_q & ~src_now;
    cnt_prev_d = cnt_s;
    // during a clear the compare history is parked low so the
    // falling MSB of the cleared count cannot arm the flag
    src_prev_d = clr_s ? 1'b0 : src_now;
    flag_d     = clr_s ? 1'b0 : (flag_q | src_fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_prev_q <= 1'b0;
      src_prev_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      cnt_prev_q <= cnt_prev_d;
      src_prev_q <= src_prev_d;
      flag_q     <= flag_d;
    end
  end

  tally_hold #(.W(WBUS)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap(cap_s),
    .d(count_flat), .flag_d(flag_q),
    .q(digits_q), .flag_q(ovf_q)
  );
endmodule

// File: rtl/tally_chk.sv
module tally_chk #(
  parameter int DIGITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr_s,
  input logic                cap_s,
  input logic                step,
  input logic                flag_q,
  input logic [4*DIGITS-1:0] count_flat,
  input logic [4*DIGITS-1:0] digits_q,
  input logic                ovf_q
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr_s) |=> $stable(count_flat));

  for (genvar g = 0; g < DIGITS; g++) begin : g_bcd
    p_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count_flat[4*g +: 4] <= 4'd9);
  end

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (count_flat == '0) && !flag_q);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_s) |=> flag_q);

  p_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_s |=> (digits_q == $past(count_flat)) && (ovf_q == $past(flag_q)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_s |=> $stable(digits_q) && $stable(ovf_q));
endmodule

bind tally_top tally_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .cap_s(cap_s), .step(step),
  .flag_q(flag_q), .count_flat(count_flat), .digits_q(digits_q), .ovf_q(ovf_q)
);

// File: tb/tb_tally_top.sv
module tb_tally_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIGITS     = 3;
  localparam int MOD        = 1000;
  localparam int W          = 4 * DIGITS;

  logic clk, rst_n, cnt_in, clr_n, load_n, ovf_in;
  logic [1:0]   ovf_sel;
  logic [W-1:0] digits_q;
  logic         ovf_q;
  logic [2:0]   msb_tap;

  int checks = 0;
  int errors = 0;
  int model  = 0;

  tally_top #(.DIGITS(DIGITS)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .clr_n(clr_n), .load_n(load_n),
    .ovf_in(ovf_in), .ovf_sel(ovf_sel), .digits_q(digits_q), .ovf_q(ovf_q),
    .msb_tap(msb_tap)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] to_bcd(input int n);
    logic [W-1:0] v;
    int r;
    r = n;
    for (int i = 0; i < DIGITS; i++) begin
      v[4*i +: 4] = 4'(r % 10);
      r = r / 10;
    end
    return v;
  endfunction

  function automatic logic [2:0] taps_of(input int n);
    logic [2:0] t;
    int r;
    r = n;
    for (int j = 0; j < 3; j++) begin
      t[j] = ((r % 10) >= 8);
      r = r / 10;
    end
    return t;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse();
    cnt_in = 1'b1; tick(2);
    cnt_in = 1'b0; tick(3);
    model = (model + 1) % MOD;
  endtask

  task automatic load();
    load_n = 1'b0; tick(3);
    load_n = 1'b1; tick(3);
  endtask

  task automatic clear();
    clr_n = 1'b0; tick(3);
    clr_n = 1'b1; tick(3);
    model = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_in = 1'b0; clr_n = 1'b1; load_n = 1'b1;
    ovf_in = 1'b0; ovf_sel = 2'd2;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R9 digits", 32'(digits_q), 32'd0);
    chk("R9 ovf", 32'(ovf_q), 32'd0);
    chk("R9 taps", 32'(msb_tap), 32'd0);

    // full sweep through rollover, flag source = top decade MSB
    for (int n = 1; n <= MOD + 3; n++) begin
      pulse();
      chk("R7 taps", 32'(msb_tap), 32'(taps_of(model)));
      if (model % 97 == 0 || model == 9 || model == 999 || n >= MOD) begin
        load();
        chk("R1 R8 digits", 32'(digits_q), 32'(to_bcd(model)));
        chk("R4 ovf top decade", 32'(ovf_q), (n >= MOD) ? 32'd1 : 32'd0);
        if (n == MOD) chk("R2 wrap", 32'(digits_q), 32'd0);
      end
    end

    // R6: captured value survives counting and clearing
    for (int k = 0; k < 5; k++) pulse();
    chk("R6 hold digits after counts", 32'(digits_q), 32'(to_bcd(3)));
    chk("R7 taps live", 32'(msb_tap), 32'(taps_of(model)));
    clear();
    chk("R6 hold digits after clear", 32'(digits_q), 32'(to_bcd(3)));
    chk("R6 hold ovf after clear", 32'(ovf_q), 32'd1);
    load();
    chk("R3 clear digits", 32'(digits_q), 32'd0);
    chk("R3 clear ovf", 32'(ovf_q), 32'd0);

    // R4 with lowest tap: MSB high at 8 and 9, falls at 10
    ovf_sel = 2'd0;
    tick(3);
    for (int k = 0; k < 9; k++) pulse();
    load();
    chk("R4 no flag before fall", 32'(ovf_q), 32'd0);
    pulse();
    load();
    chk("R4 flag on fall", 32'(ovf_q), 32'd1);
    chk("R1 digits 10", 32'(digits_q), 32'(to_bcd(10)));

    // R8: long pulse counts once
    cnt_in = 1'b1; tick(20);
    cnt_in = 1'b0; tick(20);
    model = model + 1;
    load();
    chk("R8 long pulse once", 32'(digits_q), 32'(to_bcd(model)));

    // R3 priority: one-cycle clear coincident with count edge
    cnt_in = 1'b1; tick(2);
    cnt_in = 1'b0; clr_n = 1'b0; tick(1);
    clr_n = 1'b1; tick(4);
    model = 0;
    load();
    chk("R3 clear beats count", 32'(digits_q), 32'd0);
    chk("R3 clear flag", 32'(ovf_q), 32'd0);

    // R4 external source
    ovf_sel = 2'd3;
    tick(3);
    ovf_in = 1'b1; tick(4);
    load();
    chk("R4 rising edge ignored", 32'(ovf_q), 32'd0);
    ovf_in = 1'b0; tick(4);
    load();
    chk("R4 external fall sets", 32'(ovf_q), 32'd1);
    ovf_in = 1'b1; tick(4);
    load();
    chk("R4 sticky", 32'(ovf_q), 32'd1);
    ovf_in = 1'b0;
    clear();
    load();
    chk("R3 flag cleared", 32'(ovf_q), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule